// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a small 16-bit load/store processor. It keeps a program counter and an instruction register. It fetches one 16-bit word at a time from a 256-word synchronous memory and decodes the top four bits as the opcode. It then drives the datapath for one or two execute cycles before it returns to fetch. The register file, the ALU, the memory and the output buffer sit outside the block. The sequencer only supplies their addresses, enables and selects. It takes back the ALU zero flag, and it takes the value on register read port A, which is needed to form the address for the register-indirect store.

Every instruction passes through the same front end: fetch, a wait cycle for the synchronous read, latch with program-counter increment, and decode. The instruction word holds the opcode in bits [15:12] and the first register in bits [11:8]. Bits [7:0] hold an address or an immediate; for register-register forms, bits [7:4] hold the second register. The register file is read combinationally, and its write data is chosen by `wsel_o`. Memory write data is the value on register read port A.

Top module: `seq_ctrl`

## Requirements
- R1: After reset the first cycle asserts `mrd_o` with `maddr_o` equal to 0. Each instruction is fetched by one cycle with `mrd_o` high and `maddr_o` equal to the program counter. The program counter then advances by one.
- R2: Opcode 0000 reads memory at address bits [7:0]. In the next cycle it writes register [11:8] with `wsel_o`=1 (memory data).
- R3: Opcode 0001 asserts `mwr_o` at address bits [7:0], with read port A on register [11:8].
- R4: Opcode 0010 first reads register [11:8] on port A and latches its low 8 bits. In the next cycle it asserts `mwr_o` at that latched address, with port A on register [7:4].
- R5: Opcode 0011 writes register [11:8] with `wsel_o`=2, selecting `imm_o`. `imm_o` is bits [7:0] zero-extended to 16 bits.
- R6: Opcodes 0100 and 0101 read register [11:8] on port A and register [7:4] on port B. They write the result back to register [11:8] in the same cycle, with `wsel_o`=0 and `aluop_o` set to 1 for add or 2 for subtract (A minus B).
- R7: Opcode 0110 reads register [11:8] with `aluop_o`=0 (pass A). When `zero_i` is high, the program counter is loaded with bits [7:0]. Otherwise execution continues at the next word.
- R8: Opcode 0111 reads memory at bits [7:0]. In the next cycle it raises `oen_o` for exactly one cycle, while the read data is on `mrdata_i`.
- R9: Opcode 1111 enters a halt state. `halted_o` stays high until reset, and `mrd_o`, `mwr_o` and `rfwe_o` all stay low.
- R10: Opcodes 1000 to 1110 change no register and no memory, and execution continues with the next word.
- R11: `mrd_o` and `mwr_o` are never high in the same cycle, and `rfwe_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mrdata_i | input | 16 | Synchronous memory read data |
| rdata_a_i | input | 16 | Register file read port A value |
| zero_i | input | 1 | ALU zero flag |
| wsel_o | output | 2 | Register write source: 0 ALU, 1 memory, 2 immediate |
| waddr_o | output | 4 | Register write address |
| rfwe_o | output | 1 | Register write enable |
| raddr_a_o | output | 4 | Read port A address |
| ren_a_o | output | 1 | Read port A enable |
| raddr_b_o | output | 4 | Read port B address |
| ren_b_o | output | 1 | Read port B enable |
| aluop_o | output | 2 | ALU operation: 0 pass A, 1 add, 2 subtract |
| imm_o | output | 16 | Zero-extended immediate |
| mrd_o | output | 1 | Memory read strobe |
| mwr_o | output | 1 | Memory write strobe |
| maddr_o | output | 8 | Memory address |
| oen_o | output | 1 | Output buffer enable |
| halted_o | output | 1 | High while halted |

## Verification
The add instructions read a register and write the same register in a single execute cycle. Examples are the pointer step R2 plus R3 and R1 plus R0 in the running sum. The read must therefore see the old value, and the write must land on the following edge. A Fibonacci program provokes this on every loop pass. Any mistake in the timing of that read-then-write corrupts the ten stored values and the ten values seen on the output port, which are compared with 0, 1, 1, 2, 3, 5, 8, 13, 21 and 34. A second program exercises a conditional jump that is not taken, a direct store followed by a load, and an undefined opcode.

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mrdata_i,
  input  logic [DW-1:0] rdata_a_i,
  input  logic          zero_i,
  output logic [1:0]    wsel_o,
  output logic [RW-1:0] waddr_o,
  output logic          rfwe_o,
  output logic [RW-1:0] raddr_a_o,
  output logic          ren_a_o,
  output logic [RW-1:0] raddr_b_o,
  output logic          ren_b_o,
  output logic [1:0]    aluop_o,
  output logic [DW-1:0] imm_o,
  output logic          mrd_o,
  output logic          mwr_o,
  output logic [AW-1:0] maddr_o,
  output logic          oen_o,
  output logic          halted_o
);
  typedef enum logic [2:0] {S_FETCH, S_WAIT, S_LATCH, S_DEC, S_EX1, S_EX2, S_HALT} st_t;

  st_t st;
  logic [AW-1:0] pc, ptr;
  logic [DW-1:0] ir;

  wire [3:0]    opc = ir[DW-1 -: 4];
  wire [RW-1:0] ra  = ir[DW-5 -: RW];
  wire [RW-1:0] rb  = ir[AW-1 -: RW];
  wire [AW-1:0] fld = ir[AW-1:0];

  assign imm_o    = {{(DW-AW){1'b0}}, fld};
  assign halted_o = (st == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_FETCH;
      pc  <= '0;
      ir  <= '0;
      ptr <= '0;
    end else begin
      case (st)
        S_FETCH: st <= S_WAIT;
        S_WAIT:  st <= S_LATCH;
        S_LATCH: begin
          ir <= mrdata_i;
          pc <= pc + 1'b1;
          st <= S_DEC;
        end
        S_DEC: begin
          if (opc == 4'hF)    st <= S_HALT;
          else if (!opc[3])   st <= S_EX1;
          else                st <= S_FETCH;
        end
        S_EX1: begin
          st <= S_FETCH;
          case (opc)
            4'h0, 4'h7: st <= S_EX2;
            4'h2: begin
              ptr <= rdata_a_i[AW-1:0];
              st  <= S_EX2;
            end
            4'h6: if (zero_i) pc <= fld;
            default: ;
          endcase
        end
        S_EX2:   st <= S_FETCH;
        default: st <= S_HALT;
      endcase
    end
  end

  always_comb begin
    wsel_o    = 2'd0;
    waddr_o   = ra;
    rfwe_o    = 1'b0;
    raddr_a_o = ra;
    ren_a_o   = 1'b0;
    raddr_b_o = rb;
    ren_b_o   = 1'b0;
    aluop_o   = 2'd0;
    mrd_o     = 1'b0;
    mwr_o     = 1'b0;
    maddr_o   = fld;
    oen_o     = 1'b0;
    case (st)
      S_FETCH: begin
        mrd_o   = 1'b1;
        maddr_o = pc;
      end
      S_EX1: case (opc)
        4'h0, 4'h7: mrd_o = 1'b1;
        4'h1: begin
          ren_a_o = 1'b1;
          mwr_o   = 1'b1;
        end
        4'h2, 4'h6: ren_a_o = 1'b1;
        4'h3: begin
          rfwe_o = 1'b1;
          wsel_o = 2'd2;
        end
        4'h4, 4'h5: begin
          ren_a_o = 1'b1;
          ren_b_o = 1'b1;
          aluop_o = opc[0] ? 2'd2 : 2'd1;
          rfwe_o  = 1'b1;
        end
        default: ;
      endcase
      S_EX2: case (opc)
        4'h0: begin
          rfwe_o = 1'b1;
          wsel_o = 2'd1;
        end
        4'h2: begin
          raddr_a_o = rb;
          ren_a_o   = 1'b1;
          mwr_o     = 1'b1;
          maddr_o   = ptr;
        end
        4'h7: oen_o = 1'b1;
        default: ;
      endcase
      default: ;
    endcase
  end
endmodule

module seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mrd_o,
  input logic mwr_o,
  input logic rfwe_o,
  input logic oen_o,
  input logic halted_o
);
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mrd_o && mwr_o)); // R11
  AST_WE_SPACED: assert property (@(posedge clk) disable iff (!rst_n) rfwe_o |=> !rfwe_o); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted_o |=> halted_o); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) halted_o |-> !(mrd_o || mwr_o || rfwe_o)); // R9
  AST_OUT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) oen_o |-> $past(mrd_o)); // R8
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) oen_o |=> !oen_o); // R8
endmodule

bind seq_ctrl seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mrd_o(mrd_o), .mwr_o(mwr_o),
  .rfwe_o(rfwe_o), .oen_o(oen_o), .halted_o(halted_o)
);

// File: tb/sim_seq_ctrl.sv
module sim_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] mrdata, rdata_a;
  logic zero;
  logic [1:0] wsel, aluop;
  logic [3:0] waddr, raddr_a, raddr_b;
  logic rfwe, ren_a, ren_b, mrd, mwr, oen, halted;
  logic [15:0] imm;
  logic [7:0] maddr;

  int n_tests = 0, n_fail = 0;
  logic [15:0] mem [256];
  logic [15:0] rf [16];
  logic [15:0] outs [32];
  int n_out = 0;
  int n_clash = 0, n_quiet_bad = 0, n_we_pair = 0;
  logic we_prev = 1'b0;
  logic [15:0] alu_y;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mrdata_i(mrdata), .rdata_a_i(rdata_a), .zero_i(zero),
    .wsel_o(wsel), .waddr_o(waddr), .rfwe_o(rfwe), .raddr_a_o(raddr_a), .ren_a_o(ren_a),
    .raddr_b_o(raddr_b), .ren_b_o(ren_b), .aluop_o(aluop), .imm_o(imm),
    .mrd_o(mrd), .mwr_o(mwr), .maddr_o(maddr), .oen_o(oen), .halted_o(halted)
  );

  assign rdata_a = rf[raddr_a];
  always_comb begin
    case (aluop)
      2'd1:    alu_y = rf[raddr_a] + rf[raddr_b];
      2'd2:    alu_y = rf[raddr_a] - rf[raddr_b];
      default: alu_y = rf[raddr_a];
    endcase
  end
  assign zero = (alu_y == 16'd0);

  always @(posedge clk) begin
    if (rst_n) begin
      if (mrd && !mwr) mrdata <= mem[maddr];
      if (mwr && !mrd) mem[maddr] <= rf[raddr_a];
      if (rfwe) rf[waddr] <= (wsel == 2'd0) ? alu_y : (wsel == 2'd1) ? mrdata : imm;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (oen && n_out < 32) begin outs[n_out] = mrdata; n_out++; end
      if (mrd && mwr) n_clash++;
      if (halted && (mrd || mwr || rfwe)) n_quiet_bad++;
      if (rfwe && we_prev) n_we_pair++;
      we_prev = rfwe;
    end else we_prev = 1'b0;
  end

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] r, input logic [7:0] f);
    return {op, r, f};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    n_out = 0;
    for (int i = 0; i < 16; i++) rf[i] = 16'd0;
    mrdata = 16'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(input int limit);
    int k = 0;
    while (!halted && k < limit) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 256; i++) mem[i] = 16'd0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset read strobe", {15'd0, mrd}, 16'd1);
    check("R1 reset fetch address", {8'd0, maddr}, 16'd0);
    check("R9 reset not halted", {15'd0, halted}, 16'd0);
    check("R11 reset no write", {13'd0, mwr, rfwe, oen}, 16'd0);
  endtask

  task automatic t_fibonacci();
    logic [15:0] a, b, t;
    for (int i = 0; i < 256; i++) mem[i] = 16'd0;
    mem[0]  = enc(4'h9, 4'd0, 8'h00);
    mem[1]  = enc(4'h3, 4'd0, 8'd0);
    mem[2]  = enc(4'h3, 4'd1, 8'd1);
    mem[3]  = enc(4'h3, 4'd2, 8'd50);
    mem[4]  = enc(4'h3, 4'd3, 8'd1);
    mem[5]  = enc(4'h3, 4'd4, 8'd10);
    mem[6]  = enc(4'h3, 4'd6, 8'd0);
    mem[7]  = enc(4'h2, 4'd2, 8'h00);
    mem[8]  = enc(4'h3, 4'd5, 8'd0);
    mem[9]  = enc(4'h4, 4'd5, 8'h10);
    mem[10] = enc(4'h4, 4'd1, 8'h00);
    mem[11] = enc(4'h3, 4'd0, 8'd0);
    mem[12] = enc(4'h4, 4'd0, 8'h50);
    mem[13] = enc(4'h4, 4'd2, 8'h30);
    mem[14] = enc(4'h5, 4'd4, 8'h30);
    mem[15] = enc(4'h6, 4'd4, 8'd17);
    mem[16] = enc(4'h6, 4'd6, 8'd7);
    for (int i = 0; i < 10; i++) mem[17+i] = enc(4'h7, 4'd0, 8'(50+i));
    mem[27] = enc(4'hF, 4'd0, 8'd0);
    do_reset();
    run_to_halt(20000);
    check("R9 fibonacci halts", {15'd0, halted}, 16'd1);
    check("R8 output count", 16'(n_out), 16'd10);
    a = 0; b = 1;
    for (int i = 0; i < 10; i++) begin
      check($sformatf("R4 stored word %0d", i), mem[50+i], a);
      check($sformatf("R8 output word %0d", i), outs[i], a);
      t = a + b; a = b; b = t;
    end
    check("R6 pointer register", rf[2], 16'd60);
    check("R6 counter reaches zero", rf[4], 16'd0);
    check("R7 jump target register", rf[6], 16'd0);
    check("R10 undefined word left memory unchanged", mem[0], 16'h9000);
    repeat (20) @(negedge clk);
    check("R9 halt quiet", 16'(n_quiet_bad), 16'd0);
    check("R9 halt sticky", {15'd0, halted}, 16'd1);
  endtask

  task automatic t_direct_and_fallthrough();
    for (int i = 0; i < 256; i++) mem[i] = 16'd0;
    mem[0] = enc(4'h3, 4'd1, 8'hA5);
    mem[1] = enc(4'h1, 4'd1, 8'd100);
    mem[2] = enc(4'h0, 4'd7, 8'd100);
    mem[3] = enc(4'hC, 4'd7, 8'd0);
    mem[4] = enc(4'h6, 4'd7, 8'd8);
    mem[5] = enc(4'h1, 4'd7, 8'd101);
    mem[6] = enc(4'h7, 4'd0, 8'd101);
    mem[7] = enc(4'hF, 4'd0, 8'd0);
    mem[8] = enc(4'hF, 4'd0, 8'd0);
    do_reset();
    run_to_halt(2000);
    check("R5 immediate zero-extended", rf[1], 16'h00A5);
    check("R3 direct store", mem[100], 16'h00A5);
    check("R2 direct load", rf[7], 16'h00A5);
    check("R7 not taken reaches output", 16'(n_out), 16'd1);
    check("R8 output value", outs[0], 16'h00A5);
    check("R3 second store", mem[101], 16'h00A5);
    check("R10 undefined opcode no register change", rf[12], 16'd0);
    check("R11 strobes exclusive", 16'(n_clash), 16'd0);
    check("R11 writes spaced", 16'(n_we_pair), 16'd0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_fibonacci();
        t_direct_and_fallthrough();
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule